// File: doc/BRIEF.md
# Gated Event Counter with One-Shot Gate Capture

This block is a wrapping event counter whose advance is qualified by an external gate. It counts one step for each single-cycle strobe from its clock source. It counts only while the timer is switched on and, if gating is enabled, only while the qualified gate is active. The raw gate passes through a two-stage synchronizer and an optional inversion. After that it can go through a toggle stage, which turns each full input period into one long active phase. It can also go through a one-shot stage, which lets exactly one gate pulse through after software arms it.

Software drives the block through plain control ports. A configuration write loads all mode bits at once. Separate single-cycle pulses arm the one-shot, clear the two sticky flags, or load a new counter value. A typical use is pulse-width measurement: select one-shot mode, clear the counter, arm, and read the count once the busy flag drops. If toggle mode is selected as well, the same sequence measures one full period of the gate source.

Top module: `gate_timer`

## Requirements
- R1: After reset the counter is 0 and `gateLevel`, `armBusy`, `gateIrq` and `ovfFlag` are all 0.
- R2: The counter increments by one on each clock where `cntStrobe` is 1, the timer is on, and either gating is off or `gateLevel` is 1. Otherwise it holds, and it never changes while the timer is off.
- R3: A counted strobe at the all-ones value wraps the counter to 0 and sets `ovfFlag`. The flag stays set until an `ovfClr` pulse.
- R4: A `cntWe` pulse loads `cntWdata` into the counter on the next clock. It takes priority over a strobe in the same cycle, so that strobe is lost.
- R5: With toggle and one-shot off, `gateLevel` follows `gateIn` two clocks later. It is inverted when `cfgInvert` is 1, so 1 means active-low input.
- R6: In toggle mode, `gateLevel` flips one clock after each rising edge of the polarity-adjusted gate. The toggle state is forced to 0 while toggle mode is off or the timer is off.
- R7: An `armSet` pulse sets `armBusy` only while one-shot mode is configured. Once armed, `gateLevel` passes the next complete active pulse. On that pulse's trailing edge `armBusy` clears to 0.
- R8: In one-shot mode with `armBusy` at 0, `gateLevel` stays 0 and gated counting stops, whatever the gate input does.
- R9: A configuration write with the one-shot bit at 0 clears `armBusy` on the next clock.
- R10: While gating is enabled, a falling edge of `gateLevel` sets `gateIrq` one clock later. The flag stays set until an `irqClr` pulse, and a new event wins over a clear in the same cycle.
- R11: With toggle and one-shot both on, one armed capture counts exactly one full period of the gate input, in strobe-qualified clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Load all configuration bits below |
| cfgOn | input | 1 | Timer on |
| cfgGateEn | input | 1 | Counting qualified by the gate |
| cfgInvert | input | 1 | Gate input active-low |
| cfgToggle | input | 1 | Toggle mode |
| cfgSingle | input | 1 | One-shot mode |
| armSet | input | 1 | Arm a one-shot capture |
| irqClr | input | 1 | Clear the gate-event flag |
| ovfClr | input | 1 | Clear the overflow flag |
| cntWe | input | 1 | Load the counter |
| cntWdata | input | 16 | Counter load value |
| gateIn | input | 1 | Asynchronous gate input |
| cntStrobe | input | 1 | Count-enable strobe from the clock source |
| cntValue | output | 16 | Counter value |
| gateLevel | output | 1 | Qualified gate level |
| armBusy | output | 1 | One-shot armed or in progress (0 = done) |
| gateIrq | output | 1 | Sticky gate-event flag |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
A software counter load and a qualified strobe can arrive in the same clock. The bench keeps `cntStrobe` high while it pulses `cntWe`, and the load value must appear with no extra increment. A gate-event flag clear can also coincide with a fresh falling edge of the gate. The reference model applies set-over-clear and is compared against the design on every clock.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  typedef struct packed {
    logic inc;
    logic load;
    logic ovfClr;
  } gtmr_strobe_t;
endpackage

// File: rtl/gtmr_ctrl.sv
module gtmr_ctrl
  import gtmr_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWe,
  input  logic         cfgOn,
  input  logic         cfgGateEn,
  input  logic         cfgInvert,
  input  logic         cfgToggle,
  input  logic         cfgSingle,
  input  logic         armSet,
  input  logic         irqClr,
  input  logic         ovfClr,
  input  logic         cntWe,
  input  logic         cntStrobe,
  input  logic         gateIn,
  output gtmr_strobe_t strobes,
  output logic         gateLevel,
  output logic         armBusy,
  output logic         gateIrq
);
  logic onQ, gateEnQ, invQ, tglQ, singleQ;
  logic [SYNC_N-1:0] syncQ;
  logic polGate, polPrev, togQ, tgGate, tgPrev;
  logic shotActive, goQ, qualGate, qualPrev, irqQ;
  logic leadEdge, trailEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onQ <= 1'b0; gateEnQ <= 1'b0; invQ <= 1'b0; tglQ <= 1'b0; singleQ <= 1'b0;
    end else if (cfgWe) begin
      onQ <= cfgOn; gateEnQ <= cfgGateEn; invQ <= cfgInvert;
      tglQ <= cfgToggle; singleQ <= cfgSingle;
    end
  end

  generate
    if (SYNC_N == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= gateIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_N-2:0], gateIn};
      end
    end
  endgenerate

  assign polGate = syncQ[SYNC_N-1] ^ invQ;
  assign tgGate  = tglQ ? togQ : polGate;

  // one-shot qualification: opens on an armed leading edge, shuts on trailing edge
  assign leadEdge  = goQ && tgGate && !tgPrev;
  assign trailEdge = shotActive && !tgGate;
  assign qualGate  = singleQ ? (tgGate && (shotActive || leadEdge)) : tgGate;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polPrev <= 1'b0; togQ <= 1'b0; tgPrev <= 1'b0;
      shotActive <= 1'b0; goQ <= 1'b0; qualPrev <= 1'b0; irqQ <= 1'b0;
    end else begin
      polPrev  <= polGate;
      tgPrev   <= tgGate;
      qualPrev <= qualGate;
      if (onQ && tglQ) togQ <= togQ ^ (polGate && !polPrev);
      else             togQ <= 1'b0;

      if (!singleQ)       shotActive <= 1'b0;
      else if (trailEdge) shotActive <= 1'b0;
      else if (leadEdge)  shotActive <= 1'b1;

      if (cfgWe && !cfgSingle)   goQ <= 1'b0;
      else if (armSet && singleQ) goQ <= 1'b1;
      else if (singleQ && trailEdge) goQ <= 1'b0;

      if (gateEnQ && qualPrev && !qualGate) irqQ <= 1'b1;
      else if (irqClr)                      irqQ <= 1'b0;
    end
  end

  always_comb begin
    strobes.load   = cntWe;
    strobes.inc    = cntStrobe && onQ && (!gateEnQ || qualGate);
    strobes.ovfClr = ovfClr;
  end

  assign gateLevel = qualGate;
  assign armBusy   = goQ;
  assign gateIrq   = irqQ;
endmodule

// File: rtl/gtmr_dp.sv
module gtmr_dp
  import gtmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  gtmr_strobe_t strobes,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] count,
  output logic         ovf
);
  localparam logic [W-1:0] MaxVal = {W{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (strobes.load)     count <= loadVal;
      else if (strobes.inc) count <= count + 1'b1;

      if (!strobes.load && strobes.inc && count == MaxVal) ovf <= 1'b1;
      else if (strobes.ovfClr)                             ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/gate_timer.sv
module gate_timer
  import gtmr_pkg::*;
#(
  parameter int W      = 16,
  parameter int SYNC_N = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWe,
  input  logic         cfgOn,
  input  logic         cfgGateEn,
  input  logic         cfgInvert,
  input  logic         cfgToggle,
  input  logic         cfgSingle,
  input  logic         armSet,
  input  logic         irqClr,
  input  logic         ovfClr,
  input  logic         cntWe,
  input  logic [W-1:0] cntWdata,
  input  logic         gateIn,
  input  logic         cntStrobe,
  output logic [W-1:0] cntValue,
  output logic         gateLevel,
  output logic         armBusy,
  output logic         gateIrq,
  output logic         ovfFlag
);
  gtmr_strobe_t strobes;

  gtmr_ctrl #(.SYNC_N(SYNC_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgOn(cfgOn), .cfgGateEn(cfgGateEn),
    .cfgInvert(cfgInvert), .cfgToggle(cfgToggle), .cfgSingle(cfgSingle),
    .armSet(armSet), .irqClr(irqClr), .ovfClr(ovfClr), .cntWe(cntWe),
    .cntStrobe(cntStrobe), .gateIn(gateIn), .strobes(strobes),
    .gateLevel(gateLevel), .armBusy(armBusy), .gateIrq(gateIrq)
  );

  gtmr_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadVal(cntWdata),
    .count(cntValue), .ovf(ovfFlag)
  );
endmodule

// File: rtl/gtmr_chk.sv
module gtmr_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         cfgWe,
  input logic         cfgSingle,
  input logic         irqClr,
  input logic         ovfClr,
  input logic         cntWe,
  input logic [W-1:0] cntWdata,
  input logic         cntStrobe,
  input logic [W-1:0] cntValue,
  input logic         gateIrq,
  input logic         ovfFlag,
  input logic         armBusy
);
  a_r4_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    $past(cntWe) |-> cntValue == $past(cntWdata));

  a_r2_hold_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cntWe) && !$past(cntStrobe)) |-> $stable(cntValue));

  a_r3_wrap_flags: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cntWe) && $past(cntValue) == {W{1'b1}} && cntValue == '0) |-> ovfFlag);

  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ovfFlag) && !$past(ovfClr)) |-> ovfFlag);

  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ($past(gateIrq) && !$past(irqClr)) |-> gateIrq);

  a_r9_single_off_clears: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWe && !cfgSingle) |-> !armBusy);
endmodule

bind gate_timer gtmr_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSingle(cfgSingle), .irqClr(irqClr),
  .ovfClr(ovfClr), .cntWe(cntWe), .cntWdata(cntWdata), .cntStrobe(cntStrobe),
  .cntValue(cntValue), .gateIrq(gateIrq), .ovfFlag(ovfFlag), .armBusy(armBusy)
);

// File: tb/test_gate_timer.sv
module test_gate_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 0, cfgOn = 0, cfgGateEn = 0, cfgInvert = 0, cfgToggle = 0, cfgSingle = 0;
  logic armSet = 0, irqClr = 0, ovfClr = 0, cntWe = 0, gateIn = 0, cntStrobe = 0;
  logic [15:0] cntWdata = '0;
  logic [15:0] cntValue;
  logic gateLevel, armBusy, gateIrq, ovfFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gate_timer i_gate_timer (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgOn(cfgOn), .cfgGateEn(cfgGateEn),
    .cfgInvert(cfgInvert), .cfgToggle(cfgToggle), .cfgSingle(cfgSingle),
    .armSet(armSet), .irqClr(irqClr), .ovfClr(ovfClr), .cntWe(cntWe),
    .cntWdata(cntWdata), .gateIn(gateIn), .cntStrobe(cntStrobe),
    .cntValue(cntValue), .gateLevel(gateLevel), .armBusy(armBusy),
    .gateIrq(gateIrq), .ovfFlag(ovfFlag)
  );

  // behavioural reference model
  bit mOn, mGe, mInv, mTgl, mSp;
  bit mS1, mS2, mPgPrev, mTog, mTgPrev, mShot, mGo, mQPrev, mIrq, mOvf;
  int mCnt;

  function automatic bit mTg();
    bit pg = mS2 ^ mInv;
    return mTgl ? mTog : pg;
  endfunction

  function automatic bit mQual();
    bit tg = mTg();
    if (!mSp) return tg;
    return tg && (mShot || (mGo && !mTgPrev));
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      {mOn, mGe, mInv, mTgl, mSp} = '0;
      {mS1, mS2, mPgPrev, mTog, mTgPrev, mShot, mGo, mQPrev, mIrq, mOvf} = '0;
      mCnt = 0;
    end else begin
      bit pg, tg, q, inc, nShot, nGo, nTog;
      pg = mS2 ^ mInv;
      tg = mTg();
      q  = mQual();
      inc = cntStrobe && mOn && (!mGe || q);
      nTog = (mOn && mTgl) ? (mTog ^ (pg && !mPgPrev)) : 1'b0;
      nShot = mShot;
      if (!mSp) nShot = 0;
      else if (mShot && !tg) nShot = 0;
      else if (mGo && tg && !mTgPrev) nShot = 1;
      nGo = mGo;
      if (cfgWe && !cfgSingle) nGo = 0;
      else if (armSet && mSp) nGo = 1;
      else if (mSp && mShot && !tg) nGo = 0;
      if (mGe && mQPrev && !q) mIrq = 1;
      else if (irqClr) mIrq = 0;
      if (!cntWe && inc && mCnt == 16'hFFFF) mOvf = 1;
      else if (ovfClr) mOvf = 0;
      if (cntWe) mCnt = cntWdata;
      else if (inc) mCnt = (mCnt + 1) & 16'hFFFF;
      mQPrev = q; mTgPrev = tg; mPgPrev = pg; mTog = nTog; mShot = nShot; mGo = nGo;
      mS2 = mS1; mS1 = gateIn;
      if (cfgWe) begin
        mOn = cfgOn; mGe = cfgGateEn; mInv = cfgInvert; mTgl = cfgToggle; mSp = cfgSingle;
      end
    end
  end

  task automatic expectEq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      expectEq("R2 cntValue vs model", cntValue, mCnt);
      expectEq("R5 gateLevel vs model", gateLevel, mQual());
      expectEq("R7 armBusy vs model", armBusy, mGo);
      expectEq("R10 gateIrq vs model", gateIrq, mIrq);
      expectEq("R3 ovfFlag vs model", ovfFlag, mOvf);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(bit on, bit ge, bit inv, bit tgl, bit sp);
    cfgOn = on; cfgGateEn = ge; cfgInvert = inv; cfgToggle = tgl; cfgSingle = sp;
    cfgWe = 1; tick(1); cfgWe = 0;
  endtask

  task automatic load(int v);
    cntWdata = v[15:0]; cntWe = 1; tick(1); cntWe = 0;
  endtask

  task automatic pulse(int hi, int lo);
    gateIn = 1; tick(hi); gateIn = 0; tick(lo);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (run did not finish) actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1;
    tick(1);
    // R1 reset state
    expectEq("R1 count", cntValue, 0);
    expectEq("R1 flags", {gateLevel, armBusy, gateIrq, ovfFlag}, 0);

    // R2 ungated counting and off-hold
    cfg(1, 0, 0, 0, 0);
    cntStrobe = 1; tick(5); cntStrobe = 0;
    expectEq("R2 counted", cntValue, 5);
    cfg(0, 0, 0, 0, 0);
    cntStrobe = 1; tick(3); cntStrobe = 0;
    expectEq("R2 off holds", cntValue, 5);

    // R4 load beats strobe in same cycle
    cfg(1, 0, 0, 0, 0);
    cntStrobe = 1; load(16'h1234); cntStrobe = 0;
    expectEq("R4 load wins", cntValue, 16'h1234);

    // R3 wrap and sticky overflow
    load(16'hFFFE);
    cntStrobe = 1; tick(2); cntStrobe = 0;
    expectEq("R3 wrapped", cntValue, 0);
    expectEq("R3 ovf set", ovfFlag, 1);
    tick(2);
    expectEq("R3 ovf sticky", ovfFlag, 1);
    ovfClr = 1; tick(1); ovfClr = 0;
    expectEq("R3 ovf cleared", ovfFlag, 0);

    // R5 gated, active-high, two-clock latency
    cfg(1, 1, 0, 0, 0);
    gateIn = 1; tick(1);
    expectEq("R5 not yet", gateLevel, 0);
    tick(1);
    expectEq("R5 follows", gateLevel, 1);
    cntStrobe = 1; tick(4); cntStrobe = 0;
    expectEq("R2 gated count", cntValue, 4);
    gateIn = 0; tick(3);
    expectEq("R5 low", gateLevel, 0);
    expectEq("R10 irq set", gateIrq, 1);
    tick(2);
    expectEq("R10 irq sticky", gateIrq, 1);
    irqClr = 1; tick(1); irqClr = 0;
    expectEq("R10 irq cleared", gateIrq, 0);
    cfg(1, 1, 1, 0, 0);
    expectEq("R5 inverted", gateLevel, 1);
    cntStrobe = 1; tick(2); cntStrobe = 0;
    expectEq("R2 count on inverted gate", cntValue, 6);

    // R6 toggle mode
    cfg(1, 1, 0, 1, 0);
    tick(3);
    expectEq("R6 start low", gateLevel, 0);
    pulse(2, 4);
    expectEq("R6 toggled high", gateLevel, 1);
    pulse(2, 4);
    expectEq("R6 toggled low", gateLevel, 0);
    pulse(2, 4);
    cfg(1, 1, 0, 0, 0);
    expectEq("R6 toggle off resets", gateLevel, 0);
    irqClr = 1; tick(1); irqClr = 0;

    // R7/R8 one-shot pulse capture
    cfg(1, 1, 0, 0, 1);
    load(0);
    armSet = 0; cntStrobe = 1;
    pulse(3, 4);
    expectEq("R8 unarmed no count", cntValue, 0);
    expectEq("R8 unarmed busy", armBusy, 0);
    armSet = 1; tick(1); armSet = 0;
    expectEq("R7 armed", armBusy, 1);
    tick(2);
    pulse(5, 5);
    expectEq("R7 one pulse counted", cntValue, 5);
    expectEq("R7 done", armBusy, 0);
    pulse(4, 4);
    expectEq("R8 later pulse ignored", cntValue, 5);
    cntStrobe = 0;
    irqClr = 1; tick(1); irqClr = 0;

    // R9 clearing one-shot mode clears busy; arming without the mode does nothing
    armSet = 1; tick(1); armSet = 0;
    expectEq("R9 armed first", armBusy, 1);
    cfg(1, 1, 0, 0, 0);
    expectEq("R9 busy cleared", armBusy, 0);
    armSet = 1; tick(1); armSet = 0;
    expectEq("R7 arm ignored w/o mode", armBusy, 0);

    // R11 toggle + one-shot: one full period
    cfg(1, 1, 0, 1, 1);
    load(0);
    armSet = 1; tick(1); armSet = 0;
    cntStrobe = 1;
    pulse(3, 3); pulse(3, 3); pulse(3, 3); pulse(3, 3);
    tick(4);
    cntStrobe = 0;
    expectEq("R11 period count", cntValue, 6);
    expectEq("R11 done", armBusy, 0);

    // R10 set beats clear in the same cycle
    cfg(1, 1, 0, 0, 0);
    irqClr = 1; tick(1); irqClr = 0;
    gateIn = 1; tick(4);
    gateIn = 0; tick(2);
    irqClr = 1; tick(1); irqClr = 0;
    expectEq("R10 set wins over clear", gateIrq, 1);

    tick(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule